// File: doc/BRIEF.md
# SDRAM Wide-Read Beat Splitter

This block sits between an on-chip bus master and an SDRAM command sequencer. A read request can ask for more bytes than the external data bus carries in one transfer. The block breaks that request into a chain of single-beat SDRAM reads, because the memory is always programmed for burst length 1. For each beat it derives the beat's byte address and splits it into bank, row and column fields. It then waits until the sequencer hands back that beat's data before it issues the next beat.

The returned beats are packed into a 128-bit result in address order, and a one-cycle completion pulse follows the last beat. Two configuration inputs are sampled when a request is accepted. One selects a 16-bit or 32-bit external bus. The other selects the column width of the attached x16, four-bank device: 9 bits for the 256-Mbit part or 10 bits for the 512-Mbit part. The row address is 13 bits in both cases.

Top module: `sdsplit_top`

## Requirements
- R1: While reset is applied, and on the first cycle after it, req_ready is 1 and both cmd_valid and rsp_done are 0.
- R2: The number of beats depends on req_size (0=1 byte, 1=2 bytes, 2=4 bytes, 3=16 bytes). On a 32-bit bus the counts are 1, 1, 1 and 4. On a 16-bit bus they are 1, 1, 2 and 8.
- R3: Each beat raises cmd_valid for exactly one cycle. The next cmd_valid comes only in the cycle after a clock edge that sampled beat_ack. An acknowledge given in the same cycle as cmd_valid is ignored.
- R4: For a 16-byte request, the low four address bits are treated as zero. Each later beat adds the bus width in bytes (2 or 4) to the beat address.
- R5: The word index is the beat address shifted right by 1 on a 16-bit bus, or by 2 on a 32-bit bus. With cfg_col10=0 the fields are: col = word[8:0] with cmd_col[9]=0, bank = word[10:9], row = word[23:11]. With cfg_col10=1 they are: col = word[9:0], bank = word[11:10], row = word[24:12].
- R6: The result is cleared when a request is accepted. Beat k is written at bit offset k*32 on a 32-bit bus, using all of beat_data. On a 16-bit bus it is written at offset k*16, using beat_data[15:0]. All bits that no beat writes stay zero.
- R7: rsp_done is high for exactly one cycle: the cycle after the clock edge that captured the last beat. At that point rsp_data holds the full result, and it stays unchanged until the next request is accepted.
- R8: req_ready is low from the cycle after acceptance through the rsp_done cycle. While req_ready is low, req_valid has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bus32 | input | 1 | 1: 32-bit external bus, 0: 16-bit |
| cfg_col10 | input | 1 | 1: 10-bit column device, 0: 9-bit |
| req_valid | input | 1 | Read request present |
| req_addr | input | 27 | Request byte address |
| req_size | input | 2 | Access size code (see R2) |
| req_ready | output | 1 | Block idle, request can be taken |
| cmd_valid | output | 1 | One-cycle strobe for a single-beat read |
| cmd_bank | output | 2 | Bank field of the beat |
| cmd_row | output | 13 | Row field of the beat |
| cmd_col | output | 10 | Column field of the beat |
| beat_ack | input | 1 | Sequencer returns the data of the current beat |
| beat_data | input | 32 | Returned beat data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 128 | Packed result |

## Verification
Line requests are sent on a 32-bit bus with the 9-bit column device and on a 16-bit bus with the 10-bit column device. These two runs distinguish the 4-beat and 8-beat counts, the two address step sizes, the two field slicings and the two lane packings. One line request starts from an unaligned address, which shows whether the low bits are forced to zero. Another starts near the top of the address space, which exercises the highest row bits. Single-beat and two-beat word, halfword and byte requests distinguish the size decode from the bus-width decode. Two further runs cover the ignore rules: one injects an acknowledge in the strobe cycle carrying garbage data, and the other drives a second request while the block is busy. Either would show up as a corrupted result or as an extra beat.

// File: rtl/sdsplit_pkg.sv
// Shared types for the wide-read beat splitter.
// Assumes x16 SDRAM lanes; lane width is fixed here for all submodules.
package sdsplit_pkg;
    localparam int LANE_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sdsplit_beats.sv
// Beat-count decoder: number of single-beat reads a request needs.
// Assumes the line size is a multiple of the bus width and a word fits one 32-bit beat.
module sdsplit_beats
    import sdsplit_pkg::*;
#(
    parameter int LINE_BYTES = 16,
    parameter int DBUS_W     = 32,
    parameter int CNT_W      = 4
) (
    input  logic             bus32,
    input  acc_size_e        size,
    output logic [CNT_W-1:0] beats
);
    localparam int WIDE_B   = DBUS_W / 8;
    localparam int NARROW_B = LANE_W / 8;

    // Divide the access size by the bus width, never below one beat.
    always_comb begin
        unique case (size)
            SZ_LINE: beats = bus32 ? CNT_W'(LINE_BYTES / WIDE_B) : CNT_W'(LINE_BYTES / NARROW_B);
            SZ_WORD: beats = bus32 ? CNT_W'(1) : CNT_W'(4 / NARROW_B);
            default: beats = CNT_W'(1);
        endcase
    end
endmodule

// File: rtl/sdsplit_addrmap.sv
// Address-to-field mapper: splits a beat byte address into column, bank and row.
// Assumes column bits lowest, bank next, row above; column width 9 or 10 by cfg.
module sdsplit_addrmap #(
    parameter int ADDR_W = 27,
    parameter int COL_HI = 10,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus32,
    input  logic              col10,
    output logic [COL_HI-1:0] col,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);
    logic [ADDR_W-1:0] word;

    // Drop the byte-within-beat bits to get the SDRAM word index.
    always_comb word = bus32 ? (addr >> 2) : (addr >> 1);

    // Slice fields with the boundary set by the device column width.
    always_comb begin
        if (col10) begin
            col  = word[COL_HI-1:0];
            bank = word[COL_HI +: BANK_W];
            row  = word[COL_HI+BANK_W +: ROW_W];
        end else begin
            col  = {1'b0, word[COL_HI-2:0]};
            bank = word[COL_HI-1 +: BANK_W];
            row  = word[COL_HI+BANK_W-1 +: ROW_W];
        end
    end
endmodule

// File: rtl/sdsplit_seq.sv
// Beat sequencer: accepts a request, steps the beat address and index,
// strobes one command per beat and waits for the data acknowledge.
// Assumes cfg inputs only matter at acceptance (they are latched here).
module sdsplit_seq
    import sdsplit_pkg::*;
#(
    parameter int ADDR_W     = 27,
    parameter int LINE_BYTES = 16,
    parameter int DBUS_W     = 32,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  acc_size_e         req_size,
    input  logic              cfg_bus32,
    input  logic              cfg_col10,
    input  logic              beat_ack,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic              start,
    output logic              capture,
    output logic              done,
    output logic              bus32_q,
    output logic              col10_q,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  beat_idx
);
    localparam int          ALIGN_BITS = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  beat_total;
    logic [CNT_W-1:0]  beats_req;
    logic [ADDR_W-1:0] base_addr;
    logic              last_beat;

    sdsplit_beats #(
        .LINE_BYTES(LINE_BYTES),
        .DBUS_W    (DBUS_W),
        .CNT_W     (CNT_W)
    ) u_beats (
        .bus32(cfg_bus32),
        .size (req_size),
        .beats(beats_req)
    );

    // Line requests start on a line boundary; smaller ones keep their address.
    always_comb base_addr = (req_size == SZ_LINE && ALIGN_BITS > 0) ? (req_addr & LINE_MASK) : req_addr;

    // Handshake and strobe decode from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        cmd_valid = (state == ST_ISSUE);
        done      = (state == ST_FIN);
        start     = req_valid && (state == ST_IDLE);
        capture   = beat_ack && (state == ST_WAIT);
        last_beat = (beat_idx == beat_total - CNT_W'(1));
    end

    // Request capture, beat stepping and state advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            beat_idx   <= '0;
            beat_total <= CNT_W'(1);
            bus32_q    <= 1'b0;
            col10_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_ISSUE;
                    cur_addr   <= base_addr;
                    beat_idx   <= '0;
                    beat_total <= beats_req;
                    bus32_q    <= cfg_bus32;
                    col10_q    <= cfg_col10;
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: if (capture) begin
                    if (last_beat) begin
                        state <= ST_FIN;
                    end else begin
                        state    <= ST_ISSUE;
                        beat_idx <= beat_idx + CNT_W'(1);
                        cur_addr <= cur_addr + (bus32_q ? ADDR_W'(DBUS_W / 8) : ADDR_W'(LANE_W / 8));
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdsplit_gather.sv
// Result assembler: writes each returned beat into its 16-bit lanes in address order.
// Assumes beat index below LANES; result is cleared at request acceptance.
module sdsplit_gather
    import sdsplit_pkg::*;
#(
    parameter int DBUS_W = 32,
    parameter int RES_W  = 128,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              capture,
    input  logic              bus32,
    input  logic [CNT_W-1:0]  beat_idx,
    input  logic [DBUS_W-1:0] beat_data,
    output logic [RES_W-1:0]  result
);
    localparam int LANES        = RES_W / LANE_W;
    localparam int LANES_PER_WB = DBUS_W / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic              hit;
        logic [LANE_W-1:0] src;

        // Select whether this lane is written and which half of the beat feeds it.
        always_comb begin
            hit = bus32 ? (beat_idx == CNT_W'(i / LANES_PER_WB)) : (beat_idx == CNT_W'(i));
            src = bus32 ? beat_data[(i % LANES_PER_WB)*LANE_W +: LANE_W] : beat_data[LANE_W-1:0];
        end

        // Clear on a new request, load on a matching beat capture.
        always_ff @(posedge clk) begin
            if (!rst_n || start) begin
                result[i*LANE_W +: LANE_W] <= '0;
            end else if (capture && hit) begin
                result[i*LANE_W +: LANE_W] <= src;
            end
        end
    end
endmodule

// File: rtl/sdsplit_top.sv
// Wide-read beat splitter top: turns one read request into burst-length-1
// SDRAM beats with bank/row/column fields and packs the returned data.
// Assumes a single outstanding request and an acknowledge per issued beat.
module sdsplit_top
    import sdsplit_pkg::*;
#(
    parameter int ADDR_W     = 27,
    parameter int DBUS_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int COL_HI     = 10,
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 13,
    localparam int RES_W     = LINE_BYTES * 8,
    localparam int CNT_W     = $clog2(RES_W / LANE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus32,
    input  logic              cfg_col10,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_HI-1:0] cmd_col,
    input  logic              beat_ack,
    input  logic [DBUS_W-1:0] beat_data,
    output logic              rsp_done,
    output logic [RES_W-1:0]  rsp_data
);
    logic              start;
    logic              capture;
    logic              bus32_q;
    logic              col10_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  beat_idx;

    sdsplit_seq #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .DBUS_W    (DBUS_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_size (acc_size_e'(req_size)),
        .cfg_bus32(cfg_bus32),
        .cfg_col10(cfg_col10),
        .beat_ack (beat_ack),
        .req_ready(req_ready),
        .cmd_valid(cmd_valid),
        .start    (start),
        .capture  (capture),
        .done     (rsp_done),
        .bus32_q  (bus32_q),
        .col10_q  (col10_q),
        .cur_addr (cur_addr),
        .beat_idx (beat_idx)
    );

    sdsplit_addrmap #(
        .ADDR_W(ADDR_W),
        .COL_HI(COL_HI),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W)
    ) u_map (
        .addr (cur_addr),
        .bus32(bus32_q),
        .col10(col10_q),
        .col  (cmd_col),
        .bank (cmd_bank),
        .row  (cmd_row)
    );

    sdsplit_gather #(
        .DBUS_W(DBUS_W),
        .RES_W (RES_W),
        .CNT_W (CNT_W)
    ) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .capture  (capture),
        .bus32    (bus32_q),
        .beat_idx (beat_idx),
        .beat_data(beat_data),
        .result   (rsp_data)
    );
endmodule

// File: rtl/sdsplit_props.sv
// Port-level protocol checker for sdsplit_top, attached by bind below.
// Assumes the synchronous active-low reset of the design.
module sdsplit_props #(
    parameter int RES_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cmd_valid,
    input logic             beat_ack,
    input logic             rsp_done,
    input logic [RES_W-1:0] rsp_data
);
    // R1: reset leaves the block idle with no strobes.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !cmd_valid && !rsp_done));

    // R3: command strobe lasts one cycle.
    p_cmd_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R3: a new strobe only follows an acceptance or a data acknowledge.
    p_cmd_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(beat_ack || (req_valid && req_ready)));

    // R7: completion is a single-cycle pulse.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7: result holds after completion.
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> $stable(rsp_data));

    // R8: acceptance drops ready.
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: ready stays low while beats or completion are active.
    p_busy_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || rsp_done) |-> !req_ready);
endmodule

bind sdsplit_top sdsplit_props #(.RES_W(RES_W)) i_sdsplit_props (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .cmd_valid(cmd_valid),
    .beat_ack (beat_ack),
    .rsp_done (rsp_done),
    .rsp_data (rsp_data)
);

// File: tb/test_sdsplit_top.sv
// Scoreboard bench: the driver task queues the expected beat fields and a monitor
// pops and compares them at every command strobe; the result is checked at completion.
module test_sdsplit_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_bus32 = 1'b0;
    logic         cfg_col10 = 1'b0;
    logic         req_valid = 1'b0;
    logic [26:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic         req_ready;
    logic         cmd_valid;
    logic [1:0]   cmd_bank;
    logic [12:0]  cmd_row;
    logic [9:0]   cmd_col;
    logic         beat_ack = 1'b0;
    logic [31:0]  beat_data = '0;
    logic         rsp_done;
    logic [127:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [24:0] q_cmd[$];
    bit prev_cv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdsplit_top i_sdsplit_top (
        .clk(clk), .rst_n(rst_n), .cfg_bus32(cfg_bus32), .cfg_col10(cfg_col10),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .beat_ack(beat_ack),
        .beat_data(beat_data), .rsp_done(rsp_done), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected fields per R5.
    function automatic logic [24:0] fields(input logic [26:0] a, input bit b32, input bit c10);
        logic [26:0] w;
        w = b32 ? (a >> 2) : (a >> 1);
        if (c10) return {w[11:10], w[24:12], w[9:0]};
        else     return {w[10:9], w[23:11], 1'b0, w[8:0]};
    endfunction

    // Monitor: pop expected beat fields on each strobe.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            logic [24:0] got;
            got = {cmd_bank, cmd_row, cmd_col};
            if (q_cmd.size() == 0) chk(1'b0, "R2 extra beat", 128'(got), 128'(0));
            else begin
                logic [24:0] e;
                e = q_cmd.pop_front();
                chk(got == e, "R4/R5 beat fields", 128'(got), 128'(e));
            end
            if (prev_cv) chk(1'b0, "R3 strobe longer than one cycle", 128'(1), 128'(0));
        end
        prev_cv = rst_n && cmd_valid;
    end

    task automatic do_read(input logic [26:0] a, input logic [1:0] sz, input bit b32, input bit c10,
                           input int dly, input bit stray, input bit busyreq);
        int nb;
        int bb;
        logic [26:0] base;
        logic [31:0] dat[8];
        logic [127:0] exp;
        bb = b32 ? 4 : 2;
        nb = (sz == 2'd3) ? 16 / bb : (sz == 2'd2 && !b32) ? 2 : 1;   // R2
        base = (sz == 2'd3) ? {a[26:4], 4'b0} : a;                    // R4
        exp = '0;
        for (int k = 0; k < nb; k++) begin
            logic [26:0] ba;
            ba = base + 27'(k * bb);
            q_cmd.push_back(fields(ba, b32, c10));
            dat[k] = {ba[15:0] ^ 16'h5A3C, ba[15:0] + 16'h1111 + 16'(k)};
            if (b32) exp[k*32 +: 32] = dat[k];                         // R6
            else     exp[k*16 +: 16] = dat[k][15:0];
        end
        @(negedge clk);
        cfg_bus32 = b32; cfg_col10 = c10;
        req_valid = 1'b1; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 ready low after accept", 128'(req_ready), 128'(0));
        for (int k = 0; k < nb; k++) begin
            while (!cmd_valid) @(negedge clk);
            if (stray && k == 0) begin
                beat_ack = 1'b1; beat_data = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            beat_ack = 1'b0;
            if (busyreq && k == 0) begin
                req_valid = 1'b1; req_addr = 27'h0ABCDE0; req_size = 2'd3;
            end
            repeat (dly) @(negedge clk);
            chk(!cmd_valid, "R3 no strobe before ack", 128'(cmd_valid), 128'(0));
            beat_ack = 1'b1; beat_data = dat[k];
            @(negedge clk);
            beat_ack = 1'b0;
            req_valid = 1'b0;
        end
        chk(rsp_done, "R7 done after last beat", 128'(rsp_done), 128'(1));
        chk(rsp_data == exp, "R6 packed result", rsp_data, exp);
        chk(!req_ready, "R8 ready low during done", 128'(req_ready), 128'(0));
        @(negedge clk);
        chk(!rsp_done, "R7 done is one cycle", 128'(rsp_done), 128'(0));
        chk(req_ready, "R8 ready back after done", 128'(req_ready), 128'(1));
        chk(q_cmd.size() == 0, "R2 beat count", 128'(q_cmd.size()), 128'(0));
        chk(rsp_data == exp, "R7 result held", rsp_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && !cmd_valid && !rsp_done, "R1 state in reset",
            128'({req_ready, cmd_valid, rsp_done}), 128'(3'b100));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !cmd_valid && !rsp_done, "R1 state after reset",
            128'({req_ready, cmd_valid, rsp_done}), 128'(3'b100));
        do_read(27'h0123457, 2'd3, 1'b1, 1'b0, 0, 1'b0, 1'b0); // R2 R4 R5: 4 beats, 9-bit column
        do_read(27'h0345678, 2'd3, 1'b0, 1'b1, 2, 1'b0, 1'b0); // R2 R4 R5: 8 beats, 10-bit column
        do_read(27'h7FFFFF0, 2'd3, 1'b1, 1'b1, 1, 1'b0, 1'b0); // R5 top row bits
        do_read(27'h7FFFFF3, 2'd3, 1'b0, 1'b0, 0, 1'b0, 1'b0); // R4 unaligned, 16-bit bus
        do_read(27'h0001234, 2'd2, 1'b1, 1'b0, 0, 1'b0, 1'b0); // R2 word on wide bus
        do_read(27'h0005678, 2'd2, 1'b0, 1'b1, 0, 1'b0, 1'b0); // R2 word on narrow bus
        do_read(27'h0002222, 2'd1, 1'b1, 1'b1, 0, 1'b0, 1'b0); // R2 halfword
        do_read(27'h0003331, 2'd0, 1'b0, 1'b0, 1, 1'b0, 1'b0); // R2 byte
        do_read(27'h0440040, 2'd3, 1'b1, 1'b0, 0, 1'b1, 1'b0); // R3 stray ack ignored
        do_read(27'h0550080, 2'd3, 1'b0, 1'b1, 0, 1'b0, 1'b1); // R8 busy request ignored
        repeat (3) @(negedge clk);
        chk(!cmd_valid && q_cmd.size() == 0, "R8 no late beats", 128'(q_cmd.size()), 128'(0));
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R3 watchdog: actual=hang expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule